// File: doc/BRIEF.md
# Four-Mode Single-Step Bit Shifter

This block turns a 4-bit word into one of four one-step variants of itself. A 2-bit mode input picks the variant. The choices are the word unchanged, a logical shift left by one, a logical shift right by one, or a rotate right by one. The block has no clock, no reset and no storage, so the output follows the inputs combinationally.

Each output bit is driven by its own 4-to-1 multiplexer, and each of those is a tree of three 2-to-1 multiplexers. The four data legs of every multiplexer are wired to the bit itself or to a neighbouring bit. The zero-fill positions at the two ends of the word are tied to constant 0. The word width is a parameter, and 4 is the intended width.

Top module: `bit_shifter`

## Requirements
- R1: With mode_i = 2'b00 the output equals the input (1010 gives 1010).
- R2: With mode_i = 2'b01 the word moves one place toward the most significant end, and bit 0 becomes 0 (0101 gives 1010, 1111 gives 1110).
- R3: With mode_i = 2'b10 the word moves one place toward the least significant end, and bit 3 becomes 0 (0101 gives 0010, 1111 gives 0111).
- R4: With mode_i = 2'b11 the word rotates one place toward the least significant end, and old bit 0 becomes new bit 3 (1011 gives 1101).
- R5: Bit 3 of data_i and data_o is the most significant bit. In mode 2'b01 an input of 0001 gives 0010, and in mode 2'b10 an input of 1000 gives 0100.
- R6: The mode is the multiplexer index {mode_i[1], mode_i[0]}. Index 0 selects the unchanged bit, index 3 selects the rotated bit, and 2'b01 and 2'b10 are never swapped.
- R7: The output is a pure function of the present inputs. It settles without any clock edge, and the same inputs always give the same output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| data_i | input | 4 | Word to transform, bit 3 most significant |
| mode_i | input | 2 | Operation: 00 hold, 01 shift left, 10 shift right, 11 rotate right |
| data_o | output | 4 | Transformed word |

## Verification
The bench targets the end bits, where the zero fill and the wrap-around meet. A design that rotated instead of filling with zero would give 1111 for an input of 1111 under either shift. A design with a rotate pointed the wrong way would give 0111 for 1011 instead of 1101. A mirrored bit order or swapped select bits would make left and right trade places, and the single-bit words 0001 and 1000 expose that at once. An exhaustive sweep of all 64 data and mode pairs, compared against shift and concatenation arithmetic, catches any leg of a multiplexer wired to the wrong neighbour.

// File: rtl/bit_shifter_pkg.sv
package bit_shifter_pkg;
  typedef enum logic [1:0] {
    MODE_HOLD = 2'b00,
    MODE_SHL  = 2'b01,
    MODE_SHR  = 2'b10,
    MODE_ROR  = 2'b11
  } mode_e;
endpackage

// File: rtl/bs_mux2.sv
module bs_mux2 (
  input  logic a_i,
  input  logic b_i,
  input  logic sel_i,
  output logic y_o
);
  assign y_o = sel_i ? b_i : a_i;
endmodule

// File: rtl/bs_mux4.sv
module bs_mux4 (
  input  logic [3:0] leg_i,
  input  logic [1:0] sel_i,
  output logic       y_o
);
  logic lo, hi;

  // first stage on sel_i[0], second stage on sel_i[1]
  bs_mux2 u_lo  (.a_i(leg_i[0]), .b_i(leg_i[1]), .sel_i(sel_i[0]), .y_o(lo));
  bs_mux2 u_hi  (.a_i(leg_i[2]), .b_i(leg_i[3]), .sel_i(sel_i[0]), .y_o(hi));
  bs_mux2 u_out (.a_i(lo),       .b_i(hi),       .sel_i(sel_i[1]), .y_o(y_o));

  always_comb begin
    if (sel_i == 2'b00) assert_idx0_R6: assert (y_o == leg_i[0]);
    if (sel_i == 2'b11) assert_idx3_R6: assert (y_o == leg_i[3]);
  end
endmodule

// File: rtl/bit_shifter.sv
module bit_shifter
  import bit_shifter_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] data_i,
  input  logic [1:0]       mode_i,
  output logic [WIDTH-1:0] data_o
);
  localparam int MSB = WIDTH - 1;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic [3:0] leg;
    localparam int RIDX = (i + 1) % WIDTH;

    assign leg[0] = data_i[i];
    if (i == 0) begin : g_shl_fill
      assign leg[1] = 1'b0;
    end else begin : g_shl_src
      assign leg[1] = data_i[i-1];
    end
    if (i == MSB) begin : g_shr_fill
      assign leg[2] = 1'b0;
    end else begin : g_shr_src
      assign leg[2] = data_i[i+1];
    end
    assign leg[3] = data_i[RIDX];

    bs_mux4 u_mux (.leg_i(leg), .sel_i(mode_i), .y_o(data_o[i]));
  end

  always_comb begin
    if (mode_i == MODE_HOLD) assert_hold_R1: assert (data_o == data_i);
    if (mode_i == MODE_SHL)  assert_shl_fill_R2: assert (data_o[0] == 1'b0);
    if (mode_i == MODE_SHL)  assert_shl_msb_R5: assert (data_o[MSB] == data_i[MSB-1]);
    if (mode_i == MODE_SHR)  assert_shr_fill_R3: assert (data_o[MSB] == 1'b0);
    if (mode_i == MODE_ROR)  assert_ror_wrap_R4: assert (data_o[MSB] == data_i[0]);
  end
endmodule

// File: tb/bit_shifter_bench.sv
module bit_shifter_bench;
  logic       clk = 1'b0;
  logic [3:0] data_i = '0;
  logic [1:0] mode_i = '0;
  logic [3:0] data_o;
  int n_run = 0;
  int n_fail = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  bit_shifter #(.WIDTH(4)) u_bit_shifter (.data_i(data_i), .mode_i(mode_i), .data_o(data_o));

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired act=%0d exp=%0d", cycles, 20000);
      finish_run();
    end
  end

  function automatic logic [3:0] ref_out(input logic [3:0] d, input logic [1:0] m);
    case (m)
      2'b00: return d;
      2'b01: return {d[2:0], 1'b0};
      2'b10: return {1'b0, d[3:1]};
      default: return {d[0], d[3:1]};
    endcase
  endfunction

  task automatic apply_check(input string req, input logic [3:0] d, input logic [1:0] m,
                             input logic [3:0] exp);
    @(negedge clk);
    data_i = d; mode_i = m;
    #1;
    n_run++;
    if (data_o !== exp) begin
      n_fail++;
      $display("FAIL %s d=%b m=%b act=%b exp=%b", req, d, m, data_o, exp);
    end
  endtask

  task automatic t_zero_start();
    n_run++;
    #1;
    if (data_o !== 4'b0000) begin
      n_fail++;
      $display("FAIL R7 initial act=%b exp=%b", data_o, 4'b0000);
    end
  endtask

  task automatic t_hold_R1();
    apply_check("R1", 4'b1010, 2'b00, 4'b1010);
    apply_check("R1", 4'b0110, 2'b00, 4'b0110);
  endtask

  task automatic t_shl_R2();
    apply_check("R2", 4'b0101, 2'b01, 4'b1010);
    apply_check("R2", 4'b1111, 2'b01, 4'b1110);
  endtask

  task automatic t_shr_R3();
    apply_check("R3", 4'b0101, 2'b10, 4'b0010);
    apply_check("R3", 4'b1111, 2'b10, 4'b0111);
  endtask

  task automatic t_ror_R4();
    apply_check("R4", 4'b1011, 2'b11, 4'b1101);
    apply_check("R4", 4'b0001, 2'b11, 4'b1000);
    apply_check("R4", 4'b1111, 2'b11, 4'b1111);
  endtask

  task automatic t_order_R5();
    apply_check("R5", 4'b0001, 2'b01, 4'b0010);
    apply_check("R5", 4'b1000, 2'b10, 4'b0100);
  endtask

  task automatic t_index_R6();
    apply_check("R6", 4'b0100, 2'b01, 4'b1000);
    apply_check("R6", 4'b0100, 2'b10, 4'b0010);
    apply_check("R6", 4'b0011, 2'b00, 4'b0011);
    apply_check("R6", 4'b0011, 2'b11, 4'b1001);
  endtask

  task automatic t_sweep_R7();
    for (int m = 0; m < 4; m++) begin
      for (int d = 0; d < 16; d++) begin
        apply_check("R7", 4'(d), 2'(m), ref_out(4'(d), 2'(m)));
      end
    end
    // same inputs again, change between edges only
    data_i = 4'b1011; mode_i = 2'b11;
    #0.5;
    n_run++;
    if (data_o !== 4'b1101) begin
      n_fail++;
      $display("FAIL R7 no-clock settle act=%b exp=%b", data_o, 4'b1101);
    end
  endtask

  initial begin
    t_zero_start();
    t_hold_R1();
    t_shl_R2();
    t_shr_R3();
    t_ror_R4();
    t_order_R5();
    t_index_R6();
    t_sweep_R7();
    finish_run();
  end
endmodule